// File: doc/BRIEF.md
# Three-Level Strided Address Generator

This block walks a strided region of memory and emits one byte address per step. Three nested counters drive the walk. The innermost counts words inside a line. The middle one counts lines inside a feature. The outermost counts features. Each address is the sum of four terms: the base, the current feature offset, the current line offset and the word index times a fixed step of four bytes.

A start pulse loads the configuration and clears every counter. After that, each cycle with the enable input high issues exactly one address, until the programmed number of words has been issued. A one-cycle done pulse then marks the end, and the block stays idle until the next start.

The feature loop has a roll count and two modes:
- **Rolling mode:** the feature offset grows feature by feature, then drops back to zero after the roll count, so the same region is revisited.
- **Advancing mode:** the offset stays put for a whole group of roll-count features, then steps forward once.

Per-loop update flags travel with the address. They can optionally lag it by one cycle.

The configuration fields `line_len_i`, `feat_len_i` and `feat_roll_i` must be at least one.

Top module: `strided_agen`

## Requirements
- R1: The address is `base_i + feature offset + line offset + 4 × word index`. It appears on `addr_o` with `valid_o` high in the cycle after the enabled cycle that issued it.
- R2: Enabled cycles during a run each issue exactly one address. No address is issued in a cycle with `enable_i` low, or while the block is idle.
- R3: The word index runs from 0 to `line_len_i`−1. After each completed line the line offset grows by `line_stride_i` bytes. A feature holds `feat_len_i` lines. The line offset returns to zero when a feature completes.
- R4: Rolling mode (`outer_i` = 0): the feature offset grows by `feat_stride_i` after each feature. After `feat_roll_i` features, both the feature offset and the feature index return to zero.
- R5: Advancing mode (`outer_i` = 1): the feature offset grows by `feat_stride_i` only when the feature index completes `feat_roll_i`−1. The index then returns to zero.
- R6: Exactly `trans_size_i` addresses are issued per run. A value of zero issues none and goes straight to done.
- R7: `word_upd_o` pulses with every issued address. `line_upd_o` pulses with the last word of a line. `feat_upd_o` pulses with the last word of a feature. With `DELAY_FLAGS` = 0 they coincide with `valid_o`.
- R8: With `DELAY_FLAGS` = 1 the three update flags appear exactly one cycle later than with `DELAY_FLAGS` = 0. The address and `valid_o` are unchanged.
- R9: `progress_o` is high from the cycle after start until the final address has been issued, and low otherwise.
- R10: `done_o` is high for exactly one cycle, the cycle after the final `valid_o`. The block then ignores `enable_i` until a new start.
- R11: `start_i` restarts the walk from the first address even in the middle of a run. It takes priority over `enable_i` in its own cycle, so no address is issued that cycle.
- R12: After reset all outputs are zero.
- R13: A single-loop configuration (line stride 0, feature length 1, feature stride 0) yields the linear sequence base, base+4, base+8, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load configuration, clear counters, begin a run |
| enable_i | input | 1 | Permit one step this cycle |
| base_i | input | ADDR_W | Base byte address |
| trans_size_i | input | TRANS_CNT | Number of words to issue |
| line_len_i | input | CNT | Words per line |
| line_stride_i | input | STRIDE_W | Byte distance between lines |
| feat_len_i | input | CNT | Lines per feature |
| feat_stride_i | input | STRIDE_W | Byte distance between features |
| feat_roll_i | input | CNT | Feature roll count |
| outer_i | input | 1 | 1 = advancing mode, 0 = rolling mode |
| addr_o | output | ADDR_W | Issued byte address |
| valid_o | output | 1 | `addr_o` holds a new address |
| word_upd_o | output | 1 | Word loop advanced |
| line_upd_o | output | 1 | Line completed |
| feat_upd_o | output | 1 | Feature completed |
| progress_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds two copies at the default widths (32-bit address, 16-bit transaction counter, 10-bit loop counters). One copy has `DELAY_FLAGS` = 0 and the other `DELAY_FLAGS` = 1; both receive the same stimulus, so the one-cycle flag lag is compared cycle by cycle. Small loop lengths and roll counts of one to three let several feature roll-overs occur in both modes within a few dozen words. Sparse enable patterns exercise stalls in the middle of a line and at feature boundaries.

// File: rtl/sagen_pkg.sv
package sagen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } run_state_t;

    typedef struct packed {
        logic word;
        logic line;
        logic feat;
    } upd_flags_t;

    function automatic int unsigned step_shift(input int unsigned step);
        int unsigned s;
        s = 0;
        while ((1 << s) < step) s++;
        return s;
    endfunction

endpackage

// File: rtl/sagen_loops.sv
module sagen_loops
    import sagen_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16,
    parameter int CNT      = 10,
    parameter int STEP     = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                clear_i,
    input  logic                step_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [CNT-1:0]      line_len_i,
    input  logic [STRIDE_W-1:0] line_stride_i,
    input  logic [CNT-1:0]      feat_len_i,
    input  logic [STRIDE_W-1:0] feat_stride_i,
    input  logic [CNT-1:0]      feat_roll_i,
    input  logic                outer_i,
    output logic [ADDR_W-1:0]   addr_o,
    output upd_flags_t          upd_o
);

    localparam int unsigned SH = step_shift(STEP);

    logic [CNT-1:0]    word_q, line_q, feat_q;
    logic [ADDR_W-1:0] loff_q, foff_q;
    logic              end_word, end_line, end_feat;

    assign end_word = (word_q == line_len_i - CNT'(1));
    assign end_line = (line_q == feat_len_i - CNT'(1));
    assign end_feat = (feat_q == feat_roll_i - CNT'(1));

    always_comb begin
        upd_o.word = step_i;
        upd_o.line = step_i & end_word;
        upd_o.feat = step_i & end_word & end_line;
    end

    assign addr_o = base_i + foff_q + loff_q + (ADDR_W'(word_q) << SH);

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            word_q <= '0;
            line_q <= '0;
            feat_q <= '0;
            loff_q <= '0;
            foff_q <= '0;
        end else if (step_i) begin
            if (!end_word) begin
                word_q <= word_q + CNT'(1);
            end else begin
                word_q <= '0;
                if (!end_line) begin
                    line_q <= line_q + CNT'(1);
                    loff_q <= loff_q + ADDR_W'(line_stride_i);
                end else begin
                    line_q <= '0;
                    loff_q <= '0;
                    if (!end_feat) begin
                        feat_q <= feat_q + CNT'(1);
                        if (!outer_i) foff_q <= foff_q + ADDR_W'(feat_stride_i);
                    end else begin
                        feat_q <= '0;
                        if (outer_i) foff_q <= foff_q + ADDR_W'(feat_stride_i);
                        else         foff_q <= '0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sagen_flag_pipe.sv
module sagen_flag_pipe
    import sagen_pkg::*;
#(
    parameter int DELAY = 0
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  upd_flags_t raw_i,
    output upd_flags_t flags_o
);

    upd_flags_t stage_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) stage_q <= '0;
        else       stage_q <= raw_i;
    end

    generate
        if (DELAY == 0) begin : g_direct
            assign flags_o = stage_q;
        end else begin : g_late
            upd_flags_t late_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) late_q <= '0;
                else       late_q <= stage_q;
            end
            assign flags_o = late_q;
        end
    endgenerate

endmodule

// File: rtl/strided_agen.sv
module strided_agen
    import sagen_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int STRIDE_W    = 16,
    parameter int TRANS_CNT   = 16,
    parameter int CNT         = 10,
    parameter int STEP        = 4,
    parameter int DELAY_FLAGS = 0
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 start_i,
    input  logic                 enable_i,
    input  logic [ADDR_W-1:0]    base_i,
    input  logic [TRANS_CNT-1:0] trans_size_i,
    input  logic [CNT-1:0]       line_len_i,
    input  logic [STRIDE_W-1:0]  line_stride_i,
    input  logic [CNT-1:0]       feat_len_i,
    input  logic [STRIDE_W-1:0]  feat_stride_i,
    input  logic [CNT-1:0]       feat_roll_i,
    input  logic                 outer_i,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 valid_o,
    output logic                 word_upd_o,
    output logic                 line_upd_o,
    output logic                 feat_upd_o,
    output logic                 progress_o,
    output logic                 done_o
);

    run_state_t           state_q;
    logic [TRANS_CNT-1:0] issued_q, trans_q;
    logic [ADDR_W-1:0]    base_q, cur_addr;
    logic [CNT-1:0]       llen_q, flen_q, roll_q;
    logic [STRIDE_W-1:0]  lstr_q, fstr_q;
    logic                 outer_q, issue, last_issue;
    upd_flags_t           raw_upd, flags;

    assign issue      = (state_q == ST_RUN) && enable_i && !start_i;
    assign last_issue = issue && (issued_q == trans_q - TRANS_CNT'(1));
    assign progress_o = (state_q == ST_RUN);

    sagen_loops #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .CNT(CNT), .STEP(STEP)
    ) u_loops (
        .clk_i(clk_i), .rst_i(rst_i), .clear_i(start_i), .step_i(issue),
        .base_i(base_q), .line_len_i(llen_q), .line_stride_i(lstr_q),
        .feat_len_i(flen_q), .feat_stride_i(fstr_q), .feat_roll_i(roll_q),
        .outer_i(outer_q), .addr_o(cur_addr), .upd_o(raw_upd)
    );

    sagen_flag_pipe #(.DELAY(DELAY_FLAGS)) u_flags (
        .clk_i(clk_i), .rst_i(rst_i), .raw_i(raw_upd), .flags_o(flags)
    );

    assign word_upd_o = flags.word;
    assign line_upd_o = flags.line;
    assign feat_upd_o = flags.feat;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= ST_IDLE;
            issued_q <= '0;
            trans_q  <= '0;
            base_q   <= '0;
            llen_q   <= '0;
            flen_q   <= '0;
            roll_q   <= '0;
            lstr_q   <= '0;
            fstr_q   <= '0;
            outer_q  <= 1'b0;
            addr_o   <= '0;
            valid_o  <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            valid_o <= issue;
            done_o  <= (state_q == ST_FIN);
            if (issue) addr_o <= cur_addr;
            if (start_i) begin
                base_q   <= base_i;
                trans_q  <= trans_size_i;
                llen_q   <= line_len_i;
                flen_q   <= feat_len_i;
                roll_q   <= feat_roll_i;
                lstr_q   <= line_stride_i;
                fstr_q   <= feat_stride_i;
                outer_q  <= outer_i;
                issued_q <= '0;
                state_q  <= (trans_size_i == '0) ? ST_FIN : ST_RUN;
            end else begin
                unique case (state_q)
                    ST_RUN: begin
                        if (issue) issued_q <= issued_q + TRANS_CNT'(1);
                        if (last_issue) state_q <= ST_FIN;
                    end
                    ST_FIN:  state_q <= ST_IDLE;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/strided_agen_chk.sv
module strided_agen_chk (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic enable_i,
    input logic valid_o,
    input logic word_upd_o,
    input logic line_upd_o,
    input logic feat_upd_o,
    input logic progress_o,
    input logic done_o
);

    // R2
    valid_needs_enable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> $past(enable_i));

    // R9
    valid_during_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> $past(progress_o));

    // R10
    done_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R10
    done_apart_from_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(done_o && valid_o));

    // R11
    start_blocks_issue_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> !valid_o);

    // R7
    line_implies_word_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        line_upd_o |-> word_upd_o);

    // R7
    feat_implies_line_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        feat_upd_o |-> line_upd_o);

endmodule

bind strided_agen strided_agen_chk u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .enable_i(enable_i),
    .valid_o(valid_o), .word_upd_o(word_upd_o), .line_upd_o(line_upd_o),
    .feat_upd_o(feat_upd_o), .progress_o(progress_o), .done_o(done_o)
);

// File: tb/tb_strided_agen.sv
`timescale 1ns/1ps
module tb_strided_agen;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] trans;
        logic [9:0]  ll;
        logic [15:0] ls;
        logic [9:0]  fl;
        logic [15:0] fs;
        logic [9:0]  roll;
        logic        outer;
        logic [7:0]  en;
    } cfg_t;

    localparam int NCFG = 5;
    localparam cfg_t TBL [NCFG] = '{
        '{32'h1000, 16'd6,  10'd6, 16'h0,  10'd1, 16'h0,   10'd1, 1'b0, 8'hFF},
        '{32'h2000, 16'd18, 10'd3, 16'h40, 10'd2, 16'h100, 10'd2, 1'b0, 8'hFF},
        '{32'h3000, 16'd24, 10'd2, 16'h20, 10'd2, 16'h80,  10'd2, 1'b1, 8'hB6},
        '{32'h4000, 16'd20, 10'd4, 16'h10, 10'd1, 16'h200, 10'd3, 1'b0, 8'h55},
        '{32'h5000, 16'd7,  10'd3, 16'h30, 10'd3, 16'h0,   10'd1, 1'b1, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        start_i = 1'b0;
    logic        enable_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] trans_size_i = '0;
    logic [9:0]  line_len_i = 10'd1, feat_len_i = 10'd1, feat_roll_i = 10'd1;
    logic [15:0] line_stride_i = '0, feat_stride_i = '0;
    logic        outer_i = 1'b0;

    logic [31:0] addr_o, addr_d;
    logic valid_o, word_upd_o, line_upd_o, feat_upd_o, progress_o, done_o;
    logic valid_d, word_d, line_d, feat_d, progress_d, done_d;

    int errors = 0;
    int checks = 0;
    bit mon_on = 0;

    always #10 clk = ~clk;

    strided_agen dut (
        .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .enable_i(enable_i),
        .base_i(base_i), .trans_size_i(trans_size_i), .line_len_i(line_len_i),
        .line_stride_i(line_stride_i), .feat_len_i(feat_len_i),
        .feat_stride_i(feat_stride_i), .feat_roll_i(feat_roll_i), .outer_i(outer_i),
        .addr_o(addr_o), .valid_o(valid_o), .word_upd_o(word_upd_o),
        .line_upd_o(line_upd_o), .feat_upd_o(feat_upd_o),
        .progress_o(progress_o), .done_o(done_o)
    );

    strided_agen #(.DELAY_FLAGS(1)) dut_dly (
        .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .enable_i(enable_i),
        .base_i(base_i), .trans_size_i(trans_size_i), .line_len_i(line_len_i),
        .line_stride_i(line_stride_i), .feat_len_i(feat_len_i),
        .feat_stride_i(feat_stride_i), .feat_roll_i(feat_roll_i), .outer_i(outer_i),
        .addr_o(addr_d), .valid_o(valid_d), .word_upd_o(word_d),
        .line_upd_o(line_d), .feat_upd_o(feat_d),
        .progress_o(progress_d), .done_o(done_d)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic logic [31:0] exp_addr(input cfg_t c, input int k);
        int w, lt, ln, ft;
        logic [31:0] foff;
        w  = k % int'(c.ll);
        lt = k / int'(c.ll);
        ln = lt % int'(c.fl);
        ft = lt / int'(c.fl);
        if (c.outer) foff = 32'((ft / int'(c.roll)) * int'(c.fs));
        else         foff = 32'((ft % int'(c.roll)) * int'(c.fs));
        return c.base + foff + 32'(ln * int'(c.ls)) + 32'(w * 4);
    endfunction

    function automatic logic [2:0] exp_flags(input cfg_t c, input int k);
        int w, ln;
        w  = k % int'(c.ll);
        ln = (k / int'(c.ll)) % int'(c.fl);
        return {1'b1, w == int'(c.ll) - 1,
                (w == int'(c.ll) - 1) && (ln == int'(c.fl) - 1)};
    endfunction

    // R8: delayed copy lags flags by one cycle, address and valid equal
    logic pw = 0, pl = 0, pf = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            chk({word_d, line_d, feat_d} == {pw, pl, pf}, "R8 flag lag",
                {word_d, line_d, feat_d}, {pw, pl, pf});
            chk(valid_d == valid_o && (!valid_o || addr_d == addr_o), "R8 addr",
                addr_d, addr_o);
        end
        pw = word_upd_o; pl = line_upd_o; pf = feat_upd_o;
    end

    task automatic load(input cfg_t c);
        base_i = c.base; trans_size_i = c.trans; line_len_i = c.ll;
        line_stride_i = c.ls; feat_len_i = c.fl; feat_stride_i = c.fs;
        feat_roll_i = c.roll; outer_i = c.outer;
    endtask

    task automatic run_cfg(input cfg_t c, input int idx);
        int k;
        bit prev_valid, en, fin;
        @(negedge clk);
        load(c);
        start_i = 1'b1; enable_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(progress_o == 1'b1, "R9 progress after start", progress_o, 1);
        k = 0; prev_valid = 0; fin = 0;
        for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
            en = c.en[cyc % 8];
            enable_i = en;
            @(negedge clk);
            if (valid_o) begin
                chk(en, "R2 valid without enable", valid_o, 0);
                chk(addr_o == exp_addr(c, k), $sformatf("R1 R3 R4 R5 R13 cfg%0d word%0d", idx, k),
                    addr_o, exp_addr(c, k));
                chk({word_upd_o, line_upd_o, feat_upd_o} == exp_flags(c, k), "R7 flags",
                    {word_upd_o, line_upd_o, feat_upd_o}, exp_flags(c, k));
                k++;
            end else if (en && k < int'(c.trans)) begin
                chk(0, "R2 missing issue", 0, 1);
            end
            if (done_o) begin
                chk(k == int'(c.trans), "R6 word count", k, c.trans);
                chk(prev_valid, "R10 done after last valid", prev_valid, 1);
                fin = 1;
            end
            prev_valid = valid_o;
        end
        chk(fin, "R10 done seen", fin, 1);
        enable_i = 1'b1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(!valid_o && !done_o && !progress_o, "R10 idle after done",
                {valid_o, done_o, progress_o}, 0);
        end
        enable_i = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        cfg_t c;
        int hits;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk({addr_o, valid_o, word_upd_o, line_upd_o, feat_upd_o, progress_o, done_o} == '0,
            "R12 reset outputs", {valid_o, progress_o, done_o}, 0);
        rst_i = 1'b0;
        @(negedge clk);
        mon_on = 1;
        // R2 idle ignores enable
        enable_i = 1'b1;
        @(negedge clk);
        chk(!valid_o, "R2 idle no issue", valid_o, 0);
        enable_i = 1'b0;

        for (int i = 0; i < NCFG; i++) run_cfg(TBL[i], i);

        // R6 zero-length run
        c = TBL[0]; c.trans = 16'd0;
        @(negedge clk);
        load(c); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; enable_i = 1'b1;
        hits = 0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            if (valid_o) chk(0, "R6 zero run issued", 1, 0);
            if (done_o) hits++;
        end
        chk(hits == 1, "R6 zero run done", hits, 1);
        enable_i = 1'b0;

        // R11 restart mid-run
        c = TBL[0]; c.base = 32'h9000; c.trans = 16'd10; c.ll = 10'd10;
        @(negedge clk);
        load(c); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; enable_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(valid_o && addr_o == 32'h9008, "R11 pre-restart addr", addr_o, 32'h9008);
        c.base = 32'hA000; c.trans = 16'd4;
        load(c); start_i = 1'b1;
        @(negedge clk);
        chk(!valid_o, "R11 start beats enable", valid_o, 0);
        start_i = 1'b0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk(valid_o && addr_o == 32'hA000 + 32'(4 * j), "R11 restart sequence",
                addr_o, 32'hA000 + 32'(4 * j));
        end
        @(negedge clk);
        chk(done_o && !valid_o, "R11 R10 done after restart", done_o, 1);
        enable_i = 1'b0;
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end

endmodule